// File: doc/BRIEF.md
# Fully Associative Translation Buffer with LRU Replacement

This block caches virtual-to-physical page mappings for an address translation path. It has a fixed number of slots, 64 by default. Each slot holds the following:
- a page-aligned virtual base;
- a page span in bytes;
- a physical page base;
- six attribute bits.

A slot answers a lookup when the lookup address falls inside the range that starts at its virtual base and runs for its span. The lookup does not compare tags exactly.

The lookup side is purely combinational. The caller presents a virtual address and a touch flag. In the same cycle the block returns hit, the physical address and the attributes of the matching slot. When touch is set on a hit, that slot becomes the most recently used at the next clock edge.

The insert side writes a new mapping at the next edge. It uses an unused slot while any remain, taking them in index order from the lowest. Once every slot is in use, it overwrites the least recently used slot. Recency is kept as one age per slot: 0 is the most recent, and the oldest in-use slot has the largest age.

Top module: `xlat_buffer`

## Requirements
- R1: After reset no slot is in use. Every lookup misses, and on a miss `lk_paddr` and `lk_attr` are zero.
- R2: A slot with virtual base B and span S matches address A exactly when B <= A and A < B + S. Both range bounds are inclusive of B and exclusive of B + S.
- R3: On a hit, `lk_paddr` is the slot's physical base bitwise ORed with bits 11:0 of the lookup address. Higher lookup-address bits are not used, even for spans larger than 4 KiB.
- R4: On a hit, `lk_attr` returns the attributes stored with the matching slot. The bit order is: [0] writeable, [1] user-accessible, [2] uncacheable, [3] global, [4] page-attribute index bit, [5] no-execute.
- R5: While unused slots remain, an insert evicts nothing. After ENTRIES inserts of distinct pages, every one of them still hits.
- R6: When all slots are in use, an insert replaces the least recently used slot. That page then misses, and all other pages still hit.
- R7: A hit with `lk_touch` high makes the slot the most recently used. With `lk_touch` low, the recency order is left unchanged.
- R8: When several in-use slots match one address, the most recently used of them supplies the result.
- R9: When `ins_en` and a touching hit occur in the same cycle, the insert is performed and the touch is discarded.
- R10: A newly inserted slot becomes the most recently used. Its virtual base is the supplied address with bits 11:0 cleared.
- R11: An insert is not visible to a lookup in the cycle it is presented. It becomes visible after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_vaddr | input | VA_W | Lookup virtual address |
| lk_touch | input | 1 | Mark the matching slot most recently used |
| lk_hit | output | 1 | Lookup matched an in-use slot |
| lk_paddr | output | PA_W | Translated physical address (zero on miss) |
| lk_attr | output | 6 | Attribute bits of the matching slot (zero on miss) |
| ins_en | input | 1 | Install a mapping at the next edge |
| ins_vbase | input | VA_W | Virtual page base of the new mapping |
| ins_span | input | VA_W | Page span in bytes |
| ins_pbase | input | PA_W | Physical page base |
| ins_attr | input | 6 | Attribute bits of the new mapping |

## Verification
The hardest case to reach from the ports is the collision of an insert with a touching hit on a full buffer. Its only visible effect shows up one insert later, when it becomes clear which page was evicted. The stimulus first fills every slot with no touches, so the age order equals the insertion order. It then presents an insert together with a touching hit on the second-oldest page, and follows with one more insert. Whether that second-oldest page or the page after it disappears shows whether the touch was dropped. Eviction after an explicit touch, and after an untouched hit, is checked the same way.

// File: rtl/xlb_pkg.sv
package xlb_pkg;
   localparam int ATTR_W = 6;

   // bit 0 .. bit 5 as seen on the attribute ports
   typedef struct packed {
      logic no_exec;
      logic pat_idx;
      logic global_pg;
      logic no_cache;
      logic user_ok;
      logic wr_ok;
   } xlb_attr_t;
endpackage

// File: rtl/xlb_range.sv
module xlb_range #(
   parameter int ENTRIES = 64,
   parameter int VA_W    = 32
) (
   input  logic [VA_W-1:0]               va,
   input  logic [ENTRIES-1:0]            in_use,
   input  logic [ENTRIES-1:0][VA_W-1:0]  base,
   input  logic [ENTRIES-1:0][VA_W-1:0]  span,
   output logic [ENTRIES-1:0]            match
);
   localparam int SUM_W = VA_W + 1;

   for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
      logic [SUM_W-1:0] top_excl;
      assign top_excl = {1'b0, base[i]} + {1'b0, span[i]};
      assign match[i] = in_use[i] && (base[i] <= va) && ({1'b0, va} < top_excl);
   end
endmodule

// File: rtl/xlb_pick.sv
module xlb_pick #(
   parameter int ENTRIES = 64,
   parameter int IDX_W   = $clog2(ENTRIES),
   parameter int AGE_W   = IDX_W
) (
   input  logic [ENTRIES-1:0]             match,
   input  logic [ENTRIES-1:0][AGE_W-1:0]  age,
   output logic                           hit,
   output logic [IDX_W-1:0]               idx
);
   logic [AGE_W-1:0] best_age;

   // youngest matching slot wins
   always_comb begin
      hit      = 1'b0;
      idx      = '0;
      best_age = '1;
      for (int i = 0; i < ENTRIES; i++) begin
         if (match[i] && (!hit || age[i] < best_age)) begin
            hit      = 1'b1;
            idx      = IDX_W'(i);
            best_age = age[i];
         end
      end
   end
endmodule

// File: rtl/xlb_age.sv
module xlb_age #(
   parameter int ENTRIES = 64,
   parameter int IDX_W   = $clog2(ENTRIES),
   parameter int AGE_W   = IDX_W
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           upd_en,
   input  logic [IDX_W-1:0]               upd_slot,
   output logic [ENTRIES-1:0]             in_use,
   output logic [ENTRIES-1:0][AGE_W-1:0]  age,
   output logic                           have_free,
   output logic [IDX_W-1:0]               free_idx,
   output logic [IDX_W-1:0]               lru_idx
);
   localparam int REF_W = AGE_W + 1;
   localparam logic [AGE_W-1:0] OLDEST = AGE_W'(ENTRIES - 1);

   logic [REF_W-1:0] ref_age;

   // an unused slot counts as older than everything
   assign ref_age = in_use[upd_slot] ? {1'b0, age[upd_slot]} : REF_W'(ENTRIES);

   for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
      logic             v_q;
      logic [AGE_W-1:0] a_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q <= 1'b0;
            a_q <= '0;
         end else if (upd_en) begin
            if (upd_slot == IDX_W'(i)) begin
               v_q <= 1'b1;
               a_q <= '0;
            end else if (v_q && ({1'b0, a_q} < ref_age)) begin
               a_q <= a_q + 1'b1;
            end
         end
      end

      assign in_use[i] = v_q;
      assign age[i]    = a_q;
   end

   always_comb begin
      have_free = 1'b0;
      free_idx  = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (!in_use[i]) begin
            have_free = 1'b1;
            free_idx  = IDX_W'(i);
         end
      end
   end

   always_comb begin
      lru_idx = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (in_use[i] && age[i] == OLDEST) lru_idx = IDX_W'(i);
      end
   end
endmodule

// File: rtl/xlat_buffer.sv
module xlat_buffer
   import xlb_pkg::*;
#(
   parameter int ENTRIES = 64,
   parameter int VA_W    = 32,
   parameter int PA_W    = 32,
   parameter int OFF_W   = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [VA_W-1:0]   lk_vaddr,
   input  logic              lk_touch,
   output logic              lk_hit,
   output logic [PA_W-1:0]   lk_paddr,
   output logic [ATTR_W-1:0] lk_attr,
   input  logic              ins_en,
   input  logic [VA_W-1:0]   ins_vbase,
   input  logic [VA_W-1:0]   ins_span,
   input  logic [PA_W-1:0]   ins_pbase,
   input  logic [ATTR_W-1:0] ins_attr
);
   localparam int IDX_W = $clog2(ENTRIES);
   localparam int AGE_W = IDX_W;

   initial begin
      assert (ENTRIES >= 2) else $error("ENTRIES must be at least 2");
      assert (OFF_W < VA_W && OFF_W <= PA_W) else $error("OFF_W too wide");
   end

   logic [ENTRIES-1:0][VA_W-1:0]  e_vbase;
   logic [ENTRIES-1:0][VA_W-1:0]  e_span;
   logic [ENTRIES-1:0][PA_W-1:0]  e_pbase;
   xlb_attr_t                     e_attr [ENTRIES];

   logic [ENTRIES-1:0]            slot_valid;
   logic [ENTRIES-1:0][AGE_W-1:0] slot_age;
   logic [ENTRIES-1:0]            match;
   logic                          have_free;
   logic [IDX_W-1:0]              free_idx, lru_idx, ins_slot, hit_idx;
   logic                          hit;
   logic                          upd_en;
   logic [IDX_W-1:0]              upd_slot;

   xlb_range #(.ENTRIES(ENTRIES), .VA_W(VA_W)) u_range (
      .va(lk_vaddr), .in_use(slot_valid), .base(e_vbase), .span(e_span), .match(match)
   );

   xlb_pick #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .AGE_W(AGE_W)) u_pick (
      .match(match), .age(slot_age), .hit(hit), .idx(hit_idx)
   );

   assign ins_slot = have_free ? free_idx : lru_idx;
   assign upd_en   = ins_en | (lk_touch & hit);
   assign upd_slot = ins_en ? ins_slot : hit_idx;

   xlb_age #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .AGE_W(AGE_W)) u_age (
      .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .upd_slot(upd_slot),
      .in_use(slot_valid), .age(slot_age), .have_free(have_free),
      .free_idx(free_idx), .lru_idx(lru_idx)
   );

   always_ff @(posedge clk) begin
      if (ins_en) begin
         e_vbase[ins_slot] <= {ins_vbase[VA_W-1:OFF_W], OFF_W'(0)};
         e_span[ins_slot]  <= ins_span;
         e_pbase[ins_slot] <= ins_pbase;
         e_attr[ins_slot]  <= xlb_attr_t'(ins_attr);
      end
   end

   assign lk_hit   = hit;
   assign lk_paddr = hit ? (e_pbase[hit_idx] | PA_W'(lk_vaddr[OFF_W-1:0])) : '0;
   assign lk_attr  = hit ? ATTR_W'(e_attr[hit_idx]) : '0;
endmodule

// File: rtl/xlb_chk.sv
module xlb_chk #(
   parameter int ENTRIES = 64,
   parameter int VA_W    = 32,
   parameter int PA_W    = 32,
   parameter int OFF_W   = 12,
   parameter int IDX_W   = $clog2(ENTRIES),
   parameter int AGE_W   = IDX_W
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic [VA_W-1:0]                lk_vaddr,
   input logic                           lk_hit,
   input logic [PA_W-1:0]                lk_paddr,
   input logic                           ins_en,
   input logic [ENTRIES-1:0]             valid,
   input logic [ENTRIES-1:0][AGE_W-1:0]  age,
   input logic                           upd_en,
   input logic [IDX_W-1:0]               upd_slot
);
   logic             prev_upd;
   logic [IDX_W-1:0] prev_slot;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_upd  <= 1'b0;
         prev_slot <= '0;
      end else begin
         prev_upd  <= upd_en;
         prev_slot <= upd_slot;
      end
   end

   // R1
   miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_hit |-> lk_paddr == '0);

   // R3
   offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0]);

   // R5
   fill_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_en && !(&valid)) |=> $countones(valid) == $past($countones(valid)) + 1);

   // R6
   full_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_en && (&valid)) |=> &valid);

   // R10
   mru_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      prev_upd |-> (valid[prev_slot] && age[prev_slot] == '0));

   // R7
   age_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_en |=> ($stable(age) && $stable(valid)));
endmodule

bind xlat_buffer xlb_chk #(
   .ENTRIES(ENTRIES), .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .lk_vaddr(lk_vaddr), .lk_hit(lk_hit),
   .lk_paddr(lk_paddr), .ins_en(ins_en), .valid(slot_valid), .age(slot_age),
   .upd_en(upd_en), .upd_slot(upd_slot)
);

// File: tb/xlat_buffer_test.sv
`timescale 1ns/1ps
module xlat_buffer_test;
   localparam int N = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] lk_vaddr = '0;
   logic        lk_touch = 1'b0;
   logic        lk_hit;
   logic [31:0] lk_paddr;
   logic [5:0]  lk_attr;
   logic        ins_en = 1'b0;
   logic [31:0] ins_vbase = '0, ins_span = '0, ins_pbase = '0;
   logic [5:0]  ins_attr = '0;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   xlat_buffer uut (
      .clk(clk), .rst_n(rst_n), .lk_vaddr(lk_vaddr), .lk_touch(lk_touch),
      .lk_hit(lk_hit), .lk_paddr(lk_paddr), .lk_attr(lk_attr),
      .ins_en(ins_en), .ins_vbase(ins_vbase), .ins_span(ins_span),
      .ins_pbase(ins_pbase), .ins_attr(ins_attr)
   );

   function automatic logic [31:0] vpg(int i);
      return 32'h0010_0000 + (i << 12);
   endfunction
   function automatic logic [31:0] ppg(int i);
      return 32'h8000_0000 + (i << 12);
   endfunction

   task automatic check(string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; ins_en = 1'b0; lk_touch = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic do_insert(logic [31:0] vb, logic [31:0] sp, logic [31:0] pb, logic [5:0] at);
      ins_en = 1'b1; ins_vbase = vb; ins_span = sp; ins_pbase = pb; ins_attr = at;
      @(negedge clk);
      ins_en = 1'b0;
   endtask

   // present a lookup, sample before the next edge, then spend that edge
   task automatic look(string req, logic [31:0] va, logic touch, logic exp_hit, logic [31:0] exp_pa);
      lk_vaddr = va; lk_touch = touch;
      #1;
      check({req, " hit"}, 64'(lk_hit), 64'(exp_hit));
      check({req, " paddr"}, 64'(lk_paddr), 64'(exp_pa));
      @(negedge clk);
      lk_touch = 1'b0;
   endtask

   task automatic fill_all();
      for (int i = 0; i < N; i++) do_insert(vpg(i), 32'h1000, ppg(i), 6'b000011);
   endtask

   task automatic t_reset();
      do_reset();
      lk_vaddr = 32'h0010_0000; #1;
      check("R1 hit", 64'(lk_hit), 64'd0);
      check("R1 paddr", 64'(lk_paddr), 64'd0);
      check("R1 attr", 64'(lk_attr), 64'd0);
      @(negedge clk);
   endtask

   task automatic t_range();
      do_reset();
      do_insert(32'h0001_0000, 32'h2000, 32'h8000_0000, 6'b101001);
      look("R2 low bound", 32'h0001_0000, 0, 1, 32'h8000_0000);
      look("R2 top byte", 32'h0001_1FFF, 0, 1, 32'h8000_0FFF);
      look("R2 past top", 32'h0001_2000, 0, 0, 32'h0);
      look("R2 below base", 32'h0000_FFFF, 0, 0, 32'h0);
      look("R3 upper page", 32'h0001_1ABC, 0, 1, 32'h8000_0ABC);
      lk_vaddr = 32'h0001_0004; #1;
      check("R4 attr", 64'(lk_attr), 64'(6'b101001));
      @(negedge clk);
      do_insert(32'h0003_0123, 32'h1000, 32'h4000_0000, 6'b010110);
      look("R10 base aligned", 32'h0003_0000, 0, 1, 32'h4000_0000);
      lk_vaddr = 32'h0003_0FFF; #1;
      check("R4 attr second", 64'(lk_attr), 64'(6'b010110));
      @(negedge clk);
   endtask

   task automatic t_fill();
      do_reset();
      fill_all();
      for (int i = 0; i < N; i++) look("R5 all present", vpg(i) + 32'h5A, 0, 1, ppg(i) | 32'h5A);
   endtask

   task automatic t_evict();
      // buffer is full from t_fill, untouched: page 0 oldest
      do_insert(32'h0020_0000, 32'h1000, 32'h9000_0000, 6'b0);
      look("R6 oldest gone", vpg(0), 0, 0, 32'h0);
      look("R10 new present", 32'h0020_0010, 0, 1, 32'h9000_0010);
      look("R6 next kept", vpg(1), 0, 1, ppg(1));
      look("R7 touch page1", vpg(1), 1, 1, ppg(1));
      do_insert(32'h0020_1000, 32'h1000, 32'h9000_1000, 6'b0);
      look("R7 touched kept", vpg(1), 0, 1, ppg(1));
      look("R7 page2 evicted", vpg(2), 0, 0, 32'h0);
      look("R7 untouched hit", vpg(3), 0, 1, ppg(3));
      do_insert(32'h0020_2000, 32'h1000, 32'h9000_2000, 6'b0);
      look("R7 no-touch evicted", vpg(3), 0, 0, 32'h0);
      look("R7 page4 kept", vpg(4), 0, 1, ppg(4));
   endtask

   task automatic t_overlap();
      do_reset();
      do_insert(32'h0004_0000, 32'h4000, 32'hA000_0000, 6'b0);
      do_insert(32'h0004_1000, 32'h1000, 32'hB000_0000, 6'b0);
      look("R8 newest wins", 32'h0004_1234, 0, 1, 32'hB000_0234);
      look("R8 touch wide", 32'h0004_0010, 1, 1, 32'hA000_0010);
      look("R8 touched wins", 32'h0004_1234, 0, 1, 32'hA000_0234);
   endtask

   task automatic t_prio();
      do_reset();
      fill_all();
      ins_en = 1'b1; ins_vbase = 32'h0030_0000; ins_span = 32'h1000;
      ins_pbase = 32'hC000_0000; ins_attr = 6'b0;
      lk_vaddr = vpg(1); lk_touch = 1'b1;
      #1;
      check("R9 concurrent hit", 64'(lk_hit), 64'd1);
      @(negedge clk);
      ins_en = 1'b0; lk_touch = 1'b0;
      do_insert(32'h0030_1000, 32'h1000, 32'hC000_1000, 6'b0);
      look("R9 touch dropped", vpg(1), 0, 0, 32'h0);
      look("R9 page2 kept", vpg(2), 0, 1, ppg(2));
      look("R9 insert done", 32'h0030_0000, 0, 1, 32'hC000_0000);
   endtask

   task automatic t_timing();
      do_reset();
      ins_en = 1'b1; ins_vbase = 32'h0050_0000; ins_span = 32'h1000;
      ins_pbase = 32'hD000_0000; ins_attr = 6'b1;
      lk_vaddr = 32'h0050_0000;
      #1;
      check("R11 not yet", 64'(lk_hit), 64'd0);
      @(negedge clk);
      ins_en = 1'b0;
      #1;
      check("R11 after edge", 64'(lk_hit), 64'd1);
      @(negedge clk);
   endtask

   initial begin
      t_reset();
      t_range();
      t_fill();
      t_evict();
      t_overlap();
      t_prio();
      t_timing();
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule